// File: doc/BRIEF.md
# Two-Lane Stored/Live Bus Transceiver

This block sits between two bidirectional buses, called the A side and the B side, and moves data across them in two independent lanes of `LANE_W` bits each (16 bits in total with the default two lanes of 8 bits). Each tri-state bus pin is modelled as three signals: an input vector, an output vector and a per-bit output-enable vector. Each lane keeps two hold registers. One captures the A bus and one captures the B bus. Whichever side of the lane is the receiving side is fed either the live value of the opposite bus or the value held from it.

Every lane has its own set of controls:
- an active-low output enable that isolates both sides of the lane;
- a direction bit that picks which side is driven;
- two capture strobes, one per bus;
- two source selects that choose between the live and the held value.

The capture strobes are level signals that may come from outside the clock domain. Each one is synchronised, and its rising edge loads the matching hold register exactly once. Capture does not depend on the enable or the direction, so a lane can store data while it is isolated and present it later.

Top module: `bus_xcvr`

## Requirements
- R1: A rising edge on `cap_a[l]` loads lane l's A-hold register with that lane's slice of `a_in`. The load takes effect within three clock cycles of the first clock edge that sees the strobe high, provided `a_in` is held steady over that time.
- R2: A rising edge on `cap_b[l]` loads lane l's B-hold register with that lane's slice of `b_in`, with the same timing as R1.
- R3: Capture happens for every setting of `out_en_n` and `dir_to_b`, including when the lane is isolated.
- R4: While `out_en_n[l]` is 1, every bit of lane l in both `a_oe` and `b_oe` is 0.
- R5: While `out_en_n[l]` is 0 and `dir_to_b[l]` is 0, all bits of lane l in `a_oe` are 1 and those in `b_oe` are 0. While `dir_to_b[l]` is 1, `b_oe` is all 1 and `a_oe` is all 0 for that lane. The two sides are never enabled together.
- R6: When lane l drives the A side, its slice of `a_out` equals the B-hold register if `a_src_hold[l]` is 1, and otherwise equals the live `b_in` slice. The output follows a change of select or bus in the same cycle.
- R7: When lane l drives the B side, its slice of `b_out` equals the A-hold register if `b_src_hold[l]` is 1, and otherwise equals the live `a_in` slice. The output follows a change in the same cycle.
- R8: A strobe held high loads its register once only. Bus changes made while the strobe stays high are not stored.
- R9: Synchronous reset clears both hold registers of every lane to zero.
- R10: The controls of one lane have no effect on the outputs or hold registers of the other lane.
- R11: Every output data bit whose output enable is 0 is driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| out_en_n | input | LANES | Per-lane active-low output enable |
| dir_to_b | input | LANES | Per-lane direction: 1 drives B side, 0 drives A side |
| cap_a | input | LANES | Per-lane strobe capturing the A bus on its rising edge |
| cap_b | input | LANES | Per-lane strobe capturing the B bus on its rising edge |
| a_src_hold | input | LANES | A side source: 1 held B value, 0 live B bus |
| b_src_hold | input | LANES | B side source: 1 held A value, 0 live A bus |
| a_in | input | LANES*LANE_W | A bus pin inputs |
| b_in | input | LANES*LANE_W | B bus pin inputs |
| a_out | output | LANES*LANE_W | A bus pin output data |
| a_oe | output | LANES*LANE_W | A bus pin output enables |
| b_out | output | LANES*LANE_W | B bus pin output data |
| b_oe | output | LANES*LANE_W | B bus pin output enables |

## Verification
The bench walks all sixteen combinations of enable, direction and the two selects, with different data per entry and a different combination on the second lane. A swapped select or a swapped direction then shows up as the wrong bus, or the wrong side enabled. Values stored while the lane is isolated are read back later through the stored path. A design that gated capture with the enable would return zero there instead. A strobe is held high while its bus changes, which catches a level-sensitive load that tracks the bus. Strobes on one lane are checked against the other lane's held data, and a reset in mid-run must return zero through the stored path.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_A    = 2'd1,
    SIDE_B    = 2'd2
  } drive_side_t;

  function automatic drive_side_t pick_side(input logic en_n, input logic to_b);
    if (en_n)      return SIDE_NONE;
    else if (to_b) return SIDE_B;
    else           return SIDE_A;
  endfunction

endpackage

// File: rtl/xcvr_edge_sync.sv
module xcvr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], level_in};
      prev  <= chain[LAST];
    end
  end

  assign rise = chain[LAST] & ~prev;
endmodule

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/xcvr_lane_drive.sv
module xcvr_lane_drive
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         en_n,
  input  logic         to_b,
  input  logic         a_sel_hold,
  input  logic         b_sel_hold,
  input  logic [W-1:0] a_live,
  input  logic [W-1:0] b_live,
  input  logic [W-1:0] a_held,
  input  logic [W-1:0] b_held,
  output logic [W-1:0] a_dat,
  output logic [W-1:0] a_en,
  output logic [W-1:0] b_dat,
  output logic [W-1:0] b_en
);
  drive_side_t side;
  logic [W-1:0] to_a_val, to_b_val;

  assign side     = pick_side(en_n, to_b);
  assign to_a_val = a_sel_hold ? b_held : b_live;
  assign to_b_val = b_sel_hold ? a_held : a_live;

  always_comb begin
    a_dat = '0;
    a_en  = '0;
    b_dat = '0;
    b_en  = '0;
    case (side)
      SIDE_A: begin
        a_dat = to_a_val;
        a_en  = '1;
      end
      SIDE_B: begin
        b_dat = to_b_val;
        b_en  = '1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_n,
  input  logic         to_b,
  input  logic         stb_a,
  input  logic         stb_b,
  input  logic         a_sel_hold,
  input  logic         b_sel_hold,
  input  logic [W-1:0] a_pin_in,
  input  logic [W-1:0] b_pin_in,
  output logic [W-1:0] a_pin_out,
  output logic [W-1:0] a_pin_oe,
  output logic [W-1:0] b_pin_out,
  output logic [W-1:0] b_pin_oe
);
  logic         load_a, load_b;
  logic [W-1:0] a_held, b_held;

  xcvr_edge_sync #(.STAGES(STAGES)) u_sync_a (
    .clk(clk), .rst(rst), .level_in(stb_a), .rise(load_a)
  );
  xcvr_edge_sync #(.STAGES(STAGES)) u_sync_b (
    .clk(clk), .rst(rst), .level_in(stb_b), .rise(load_b)
  );

  xcvr_hold_reg #(.W(W)) u_hold_a (
    .clk(clk), .rst(rst), .load(load_a), .d(a_pin_in), .q(a_held)
  );
  xcvr_hold_reg #(.W(W)) u_hold_b (
    .clk(clk), .rst(rst), .load(load_b), .d(b_pin_in), .q(b_held)
  );

  xcvr_lane_drive #(.W(W)) u_drive (
    .en_n(en_n), .to_b(to_b),
    .a_sel_hold(a_sel_hold), .b_sel_hold(b_sel_hold),
    .a_live(a_pin_in), .b_live(b_pin_in),
    .a_held(a_held), .b_held(b_held),
    .a_dat(a_pin_out), .a_en(a_pin_oe),
    .b_dat(b_pin_out), .b_en(b_pin_oe)
  );
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
  parameter int LANES       = 2,
  parameter int LANE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int W          = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] out_en_n,
  input  logic [LANES-1:0] dir_to_b,
  input  logic [LANES-1:0] cap_a,
  input  logic [LANES-1:0] cap_b,
  input  logic [LANES-1:0] a_src_hold,
  input  logic [LANES-1:0] b_src_hold,
  input  logic [W-1:0]     a_in,
  input  logic [W-1:0]     b_in,
  output logic [W-1:0]     a_out,
  output logic [W-1:0]     a_oe,
  output logic [W-1:0]     b_out,
  output logic [W-1:0]     b_oe
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    xcvr_lane #(.W(LANE_W), .STAGES(SYNC_STAGES)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .en_n       (out_en_n[l]),
      .to_b       (dir_to_b[l]),
      .stb_a      (cap_a[l]),
      .stb_b      (cap_b[l]),
      .a_sel_hold (a_src_hold[l]),
      .b_sel_hold (b_src_hold[l]),
      .a_pin_in   (a_in[l*LANE_W +: LANE_W]),
      .b_pin_in   (b_in[l*LANE_W +: LANE_W]),
      .a_pin_out  (a_out[l*LANE_W +: LANE_W]),
      .a_pin_oe   (a_oe[l*LANE_W +: LANE_W]),
      .b_pin_out  (b_out[l*LANE_W +: LANE_W]),
      .b_pin_oe   (b_oe[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/bus_xcvr_chk.sv
module bus_xcvr_chk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int W     = LANES * LANE_W
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] out_en_n,
  input logic [LANES-1:0] dir_to_b,
  input logic [LANES-1:0] a_src_hold,
  input logic [LANES-1:0] b_src_hold,
  input logic [W-1:0]     a_in,
  input logic [W-1:0]     b_in,
  input logic [W-1:0]     a_out,
  input logic [W-1:0]     a_oe,
  input logic [W-1:0]     b_out,
  input logic [W-1:0]     b_oe
);
  assert_one_side_R5: assert property (@(posedge clk) disable iff (rst)
    (a_oe & b_oe) == '0);

  assert_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    ((a_out & ~a_oe) == '0) && ((b_out & ~b_oe) == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    assert_isolated_R4: assert property (@(posedge clk) disable iff (rst)
      out_en_n[l] |-> (a_oe[l*LANE_W +: LANE_W] == '0) && (b_oe[l*LANE_W +: LANE_W] == '0));

    assert_a_live_R6: assert property (@(posedge clk) disable iff (rst)
      (!out_en_n[l] && !dir_to_b[l] && !a_src_hold[l])
        |-> a_out[l*LANE_W +: LANE_W] == b_in[l*LANE_W +: LANE_W]);

    assert_b_live_R7: assert property (@(posedge clk) disable iff (rst)
      (!out_en_n[l] && dir_to_b[l] && !b_src_hold[l])
        |-> b_out[l*LANE_W +: LANE_W] == a_in[l*LANE_W +: LANE_W]);
  end
endmodule

bind bus_xcvr bus_xcvr_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst(rst), .out_en_n(out_en_n), .dir_to_b(dir_to_b),
  .a_src_hold(a_src_hold), .b_src_hold(b_src_hold),
  .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
  .b_out(b_out), .b_oe(b_oe)
);

// File: tb/bus_xcvr_tb.sv
`timescale 1ns/1ps
module bus_xcvr_tb;
  localparam int LANES = 2;
  localparam int LW    = 8;
  localparam int W     = LANES * LW;

  // entry = {out_en_n, dir_to_b, a_src_hold, b_src_hold, exp_a_oe, exp_b_oe}
  localparam logic [5:0] TABLE [16] = '{
    6'b0000_10, 6'b0001_10, 6'b0010_10, 6'b0011_10,
    6'b0100_01, 6'b0101_01, 6'b0110_01, 6'b0111_01,
    6'b1000_00, 6'b1001_00, 6'b1010_00, 6'b1011_00,
    6'b1100_00, 6'b1101_00, 6'b1110_00, 6'b1111_00
  };

  logic clk = 1'b0;
  logic rst;
  logic [LANES-1:0] out_en_n, dir_to_b, cap_a, cap_b, a_src_hold, b_src_hold;
  logic [W-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;

  logic [LANES-1:0][LW-1:0] m_ah, m_bh;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  bus_xcvr #(.LANES(LANES), .LANE_W(LW)) u_dut (
    .clk(clk), .rst(rst), .out_en_n(out_en_n), .dir_to_b(dir_to_b),
    .cap_a(cap_a), .cap_b(cap_b), .a_src_hold(a_src_hold), .b_src_hold(b_src_hold),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic check_all(input string req);
    logic [W-1:0] ea, eao, eb, ebo;
    for (int l = 0; l < LANES; l++) begin
      logic da, db;
      da = !out_en_n[l] && !dir_to_b[l];
      db = !out_en_n[l] &&  dir_to_b[l];
      eao[l*LW +: LW] = {LW{da}};
      ebo[l*LW +: LW] = {LW{db}};
      ea[l*LW +: LW]  = da ? (a_src_hold[l] ? m_bh[l] : b_in[l*LW +: LW]) : '0;
      eb[l*LW +: LW]  = db ? (b_src_hold[l] ? m_ah[l] : a_in[l*LW +: LW]) : '0;
    end
    check({req, " a_oe"}, a_oe, eao);
    check({req, " b_oe"}, b_oe, ebo);
    check({req, " a_out"}, a_out, ea);
    check({req, " b_out"}, b_out, eb);
  endtask

  task automatic strobe(input int lane, input bit side_b);
    if (side_b) cap_b[lane] = 1'b1; else cap_a[lane] = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    if (side_b) begin
      m_bh[lane] = b_in[lane*LW +: LW];
      cap_b[lane] = 1'b0;
    end else begin
      m_ah[lane] = a_in[lane*LW +: LW];
      cap_a[lane] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    out_en_n = '1; dir_to_b = '0; cap_a = '0; cap_b = '0;
    a_src_hold = '0; b_src_hold = '0;
    a_in = 16'hA55A; b_in = 16'h0FF0;
    m_ah = '0; m_bh = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    settle();

    // R4 R11 reset state: isolated, nothing driven
    check_all("R4/R11 reset isolated");

    // R9 held registers read back zero after reset
    out_en_n = '0; dir_to_b = '1; b_src_hold = '1; settle();
    check("R9 A-hold zero", b_out, '0);
    dir_to_b = '0; a_src_hold = '1; settle();
    check("R9 B-hold zero", a_out, '0);

    // R3 R1 store A while isolated
    out_en_n = '1;
    a_in = 16'h965A; strobe(0, 1'b0); strobe(1, 1'b0);
    // R2 R3 store B while lane drives B side
    out_en_n = '0; dir_to_b = '1; b_src_hold = '0;
    b_in = 16'h3CC3; strobe(0, 1'b1); strobe(1, 1'b1);
    out_en_n = '1; settle();
    check_all("R3 after stores");

    // R1 R2 R5 R6 R7 table walk; lane 1 uses mirrored entry (R10)
    for (int i = 0; i < 16; i++) begin
      logic [5:0] e0, e1;
      e0 = TABLE[i];
      e1 = TABLE[15 - i];
      {out_en_n[0], dir_to_b[0], a_src_hold[0], b_src_hold[0]} = e0[5:2];
      {out_en_n[1], dir_to_b[1], a_src_hold[1], b_src_hold[1]} = e1[5:2];
      a_in = 16'h1E71 ^ {8'(i * 17), 8'(i * 3)};
      b_in = 16'hE42B ^ {8'(i * 5), 8'(i * 29)};
      #1;
      check("R5 table a_oe lane0", W'(a_oe[0]), W'(e0[1]));
      check("R5 table b_oe lane0", W'(b_oe[0]), W'(e0[0]));
      check_all("R6/R7 table");
      settle();
    end

    // R8 strobe held high: later bus changes not stored
    out_en_n = '1;
    a_in[7:0] = 8'h11;
    cap_a[0] = 1'b1;
    repeat (5) @(posedge clk);
    #1 a_in[7:0] = 8'h22;
    repeat (6) @(posedge clk);
    #1 cap_a[0] = 1'b0;
    m_ah[0] = 8'h11;
    repeat (3) @(posedge clk);
    #1 out_en_n = '0; dir_to_b = '1; b_src_hold = '1; settle();
    check("R8 single load", W'(b_out[7:0]), W'(8'h11));

    // R10 strobe lane 1 only, lane 0 held data unchanged
    out_en_n = '1;
    a_in = 16'h7788; b_in = 16'h99AA;
    strobe(1, 1'b0); strobe(1, 1'b1);
    out_en_n = '0; dir_to_b = '1; b_src_hold = '1; settle();
    check_all("R10 lane1 strobe B view");
    dir_to_b = '0; a_src_hold = '1; settle();
    check_all("R10 lane1 strobe A view");

    // R9 mid-run reset clears held data
    rst = 1'b1; settle(); #1 rst = 1'b0;
    m_ah = '0; m_bh = '0; settle();
    check("R9 reset B-hold", a_out, '0);
    dir_to_b = '1; settle();
    check("R9 reset A-hold", b_out, '0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule